// File: doc/BRIEF.md
# Nested Priority Interrupt Controller

This block gathers a bank of interrupt sources and drives a single active-low request line towards a processor. Each source has an enable bit, a priority from 0 to 7, a trigger mode (rising edge or level) and a vector word. Software services an interrupt by reading the vector register. That read picks the winning source, returns its vector word, releases the request line, clears an edge-triggered source and makes the winner the interrupt in service.

The block remembers which interrupts are in service on a small stack, so a more urgent source can preempt the one being handled. Writing the end-of-interrupt register drops back to the interrupt that was interrupted. The request line is asserted only for a source that is more urgent than the one in service, and it comes back after a pop if a waiting source now qualifies. All settings sit behind a simple single-cycle register bus whose read data is registered.

Top module: `nest_irq_ctrl`

## Requirements
- R1: Arbitration considers only sources that are both pending and enabled. The highest priority value wins (7 is most urgent), and on equal priority the lower source index wins.
- R2: A read of the vector register puts on `bus_rdata`, in the cycle after the strobe, the vector word of the winning source. If no source qualifies under R6, the read returns the spurious vector instead and the in-service state does not change.
- R3: In the cycle after a vector-register read, `irq_n` is high, whatever is pending.
- R4: An edge-mode source becomes pending on a rising edge of its input, seen after a two-flop synchroniser. A vector read that selects it clears that pending flag. If a new rising edge is captured in the same cycle as the clear, the flag stays set. In the pending register, a write of 1 sets an edge-mode bit and a write of 0 clears it.
- R5: A qualifying vector read pushes the interrupt in service (level and index), and the winner becomes the interrupt in service.
- R6: `irq_n` is low, one cycle after the state that causes it, exactly when some pending, enabled source has a priority strictly above the current level. With nothing in service, the current level counts as below priority 0.
- R7: A write to the end-of-interrupt register pops the stack and restores the previous level and index.
- R8: After a pop, `irq_n` is asserted again if a waiting source has a priority above the restored level. Nesting holds up to 8 levels deep, one for each priority.
- R9: An end-of-interrupt write with nothing in service is ignored, and later nesting still restores correctly.
- R10: A level-mode source is pending exactly while its synchronised input is high. Neither a vector read nor a pending-register write changes it.
- R11: The register word addresses (N = 32 sources) are: vector word of source i at i, and priority of source i at N+i in bits [2:0]. Enable mask is at 2N, mode mask at 2N+1 (bit = 1 for edge), pending at 2N+2, vector read at 2N+3, end-of-interrupt at 2N+4 and spurious vector at 2N+5. Bit i of each mask belongs to source i. After reset, masks and pending read 0 and `irq_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| src_in | input | N_SRC | Raw interrupt source inputs, asynchronous |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Register word address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data, valid the cycle after the strobe |
| irq_n | output | 1 | Active-low interrupt request to the processor |

## Verification
The edge-capture path and the vector-read clear can hit the same pending flag in the same cycle. The bench provokes this by first setting an edge source's flag through the pending register. It then raises that source's input and times the vector-read strobe to land on the exact clock edge where the synchronised rising edge is captured. The read must return that source's vector, and a later read of the pending register must still show the flag set. A control case, where the read clears the flag with no new edge, must show it cleared.

// File: rtl/nirq_pkg.sv
package nirq_pkg;
  // Offsets of the control words, counted from the control base (2*N_SRC)
  localparam int unsigned OFS_ENABLE = 0;
  localparam int unsigned OFS_MODE   = 1;
  localparam int unsigned OFS_PEND   = 2;
  localparam int unsigned OFS_VECRD  = 3;
  localparam int unsigned OFS_EOI    = 4;
  localparam int unsigned OFS_SPUR   = 5;
endpackage

// File: rtl/nirq_pending.sv
module nirq_pending #(
  parameter int N_SRC = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_SRC-1:0] src_in,
  input  logic [N_SRC-1:0] edge_mode,
  input  logic             sw_wr,
  input  logic [N_SRC-1:0] sw_val,
  input  logic [N_SRC-1:0] clr_mask,
  output logic [N_SRC-1:0] pend
);
  logic [N_SRC-1:0] sync_a, sync_b, sync_c, edge_q, rise;

  assign rise = sync_b & ~sync_c;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_a <= '0;
      sync_b <= '0;
      sync_c <= '0;
      edge_q <= '0;
    end else begin
      sync_a <= src_in;
      sync_b <= sync_a;
      sync_c <= sync_b;
      // a freshly captured edge always survives a clear in the same cycle
      edge_q <= rise | (sw_wr ? sw_val : (edge_q & ~clr_mask));
    end
  end

  assign pend = (edge_mode & edge_q) | (~edge_mode & sync_b);

  // R4: a cleared flag without a new edge is gone next cycle
  a_r4_edge_clear: assert property (@(posedge clk) disable iff (rst)
    !sw_wr |=> ((edge_q & $past(clr_mask & ~rise)) == '0));
  // R4: a captured edge is never lost
  a_r4_edge_set: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (($past(rise) & ~edge_q) == '0));
endmodule

// File: rtl/nirq_arbiter.sv
module nirq_arbiter #(
  parameter int N_SRC  = 32,
  parameter int PRIO_W = 3,
  parameter int ID_W   = 5
) (
  input  logic [N_SRC-1:0]        req,
  input  logic [N_SRC*PRIO_W-1:0] prio_flat,
  output logic                    any,
  output logic [ID_W-1:0]         win_id,
  output logic [PRIO_W-1:0]       win_prio
);
  always_comb begin
    any      = 1'b0;
    win_id   = '0;
    win_prio = '0;
    for (int i = 0; i < N_SRC; i++) begin
      // strict compare keeps the lower index on a tie
      if (req[i] && (!any || prio_flat[i*PRIO_W +: PRIO_W] > win_prio)) begin
        any      = 1'b1;
        win_id   = ID_W'(i);
        win_prio = prio_flat[i*PRIO_W +: PRIO_W];
      end
    end
  end
endmodule

// File: rtl/nirq_level_stack.sv
module nirq_level_stack #(
  parameter int PRIO_W = 3,
  parameter int ID_W   = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push,
  input  logic [PRIO_W-1:0] push_lvl,
  input  logic [ID_W-1:0]   push_id,
  input  logic              pop,
  output logic              cur_valid,
  output logic [PRIO_W-1:0] cur_lvl,
  output logic [ID_W-1:0]   cur_id
);
  localparam int DEPTH = 1 << PRIO_W;
  localparam int IDX_W = PRIO_W;
  localparam int ENT_W = PRIO_W + ID_W;

  logic [ENT_W-1:0] mem [DEPTH];
  logic [IDX_W-1:0] sp, rd_idx;
  logic             full, do_push, do_pop;
  logic [IDX_W:0]   depth;

  assign rd_idx  = sp - 1'b1;
  assign full    = cur_valid && (sp == IDX_W'(DEPTH - 1));
  assign do_push = push && !full;
  assign do_pop  = pop && cur_valid;
  assign depth   = {1'b0, sp} + (IDX_W + 1)'(cur_valid);

  always_ff @(posedge clk) begin
    if (do_push && cur_valid) mem[sp] <= {cur_lvl, cur_id};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sp        <= '0;
      cur_valid <= 1'b0;
      cur_lvl   <= '0;
      cur_id    <= '0;
    end else if (do_push) begin
      if (cur_valid) sp <= sp + 1'b1;
      cur_valid <= 1'b1;
      cur_lvl   <= push_lvl;
      cur_id    <= push_id;
    end else if (do_pop) begin
      if (sp == '0) begin
        cur_valid <= 1'b0;
      end else begin
        {cur_lvl, cur_id} <= mem[rd_idx];
        sp                <= rd_idx;
      end
    end
  end

  // R5: each push deepens nesting by one
  a_r5_push_depth: assert property (@(posedge clk) disable iff (rst)
    do_push |=> depth == $past(depth) + 1'b1);
  // R6: only a strictly higher level may nest
  a_r6_push_above: assert property (@(posedge clk) disable iff (rst)
    (push && cur_valid) |-> push_lvl > cur_lvl);
  // R7: each effective pop shortens nesting by one
  a_r7_pop_depth: assert property (@(posedge clk) disable iff (rst)
    do_pop |=> depth == $past(depth) - 1'b1);
  // R8: nesting never exceeds one entry per level
  a_r8_no_overflow: assert property (@(posedge clk) disable iff (rst)
    !(push && full));
  // R9: a pop with nothing in service leaves the stack empty
  a_r9_eoi_empty: assert property (@(posedge clk) disable iff (rst)
    (pop && !cur_valid) |=> (!cur_valid && sp == '0));
endmodule

// File: rtl/nest_irq_ctrl.sv
module nest_irq_ctrl
  import nirq_pkg::*;
#(
  parameter int N_SRC  = 32,
  parameter int PRIO_W = 3,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_SRC-1:0]  src_in,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_n
);
  localparam int ID_W     = $clog2(N_SRC);
  localparam int PRI_BASE = N_SRC;
  localparam int CTL_BASE = 2 * N_SRC;
  localparam logic [ADDR_W-1:0] A_PRI = ADDR_W'(PRI_BASE);
  localparam logic [ADDR_W-1:0] A_CTL = ADDR_W'(CTL_BASE);
  localparam logic [ADDR_W-1:0] A_EN  = ADDR_W'(CTL_BASE + OFS_ENABLE);
  localparam logic [ADDR_W-1:0] A_MOD = ADDR_W'(CTL_BASE + OFS_MODE);
  localparam logic [ADDR_W-1:0] A_PND = ADDR_W'(CTL_BASE + OFS_PEND);
  localparam logic [ADDR_W-1:0] A_VRD = ADDR_W'(CTL_BASE + OFS_VECRD);
  localparam logic [ADDR_W-1:0] A_EOI = ADDR_W'(CTL_BASE + OFS_EOI);
  localparam logic [ADDR_W-1:0] A_SPR = ADDR_W'(CTL_BASE + OFS_SPUR);

  logic [DATA_W-1:0] vec_mem [N_SRC];
  logic [PRIO_W-1:0] prio_q  [N_SRC];
  logic [N_SRC*PRIO_W-1:0] prio_flat;
  logic [N_SRC-1:0]  en_q, mode_q, pend, clr_mask;
  logic [DATA_W-1:0] spur_q;

  logic bus_rd, bus_we, in_vec, in_pri;
  logic ivr_rd, eoi_wr, pnd_wr, push, qualify;
  logic any;
  logic [ID_W-1:0]   win_id, cur_id, tbl_idx;
  logic [PRIO_W-1:0] win_prio, cur_lvl;
  logic              cur_valid;

  assign bus_rd  = bus_sel && !bus_wr;
  assign bus_we  = bus_sel && bus_wr;
  assign in_vec  = bus_addr < A_PRI;
  assign in_pri  = (bus_addr >= A_PRI) && (bus_addr < A_CTL);
  assign tbl_idx = bus_addr[ID_W-1:0];
  assign ivr_rd  = bus_rd && (bus_addr == A_VRD);
  assign eoi_wr  = bus_we && (bus_addr == A_EOI);
  assign pnd_wr  = bus_we && (bus_addr == A_PND);

  // vector words: single write port, registered read below
  always_ff @(posedge clk) begin
    if (bus_we && in_vec) vec_mem[tbl_idx] <= bus_wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= '0;
      mode_q <= '0;
      spur_q <= '0;
      for (int i = 0; i < N_SRC; i++) prio_q[i] <= '0;
    end else if (bus_we) begin
      if (in_pri)             prio_q[tbl_idx] <= bus_wdata[PRIO_W-1:0];
      if (bus_addr == A_EN)   en_q   <= bus_wdata[N_SRC-1:0];
      if (bus_addr == A_MOD)  mode_q <= bus_wdata[N_SRC-1:0];
      if (bus_addr == A_SPR)  spur_q <= bus_wdata;
    end
  end

  for (genvar g = 0; g < N_SRC; g++) begin : g_flat
    assign prio_flat[g*PRIO_W +: PRIO_W] = prio_q[g];
  end

  nirq_pending #(.N_SRC(N_SRC)) pend_i (
    .clk(clk), .rst(rst), .src_in(src_in), .edge_mode(mode_q),
    .sw_wr(pnd_wr), .sw_val(bus_wdata[N_SRC-1:0]), .clr_mask(clr_mask),
    .pend(pend)
  );

  nirq_arbiter #(.N_SRC(N_SRC), .PRIO_W(PRIO_W), .ID_W(ID_W)) arb_i (
    .req(pend & en_q), .prio_flat(prio_flat),
    .any(any), .win_id(win_id), .win_prio(win_prio)
  );

  assign qualify  = any && (!cur_valid || (win_prio > cur_lvl));
  assign push     = ivr_rd && qualify;
  assign clr_mask = push ? (N_SRC'(1) << win_id) : '0;

  nirq_level_stack #(.PRIO_W(PRIO_W), .ID_W(ID_W)) stk_i (
    .clk(clk), .rst(rst), .push(push), .push_lvl(win_prio), .push_id(win_id),
    .pop(eoi_wr), .cur_valid(cur_valid), .cur_lvl(cur_lvl), .cur_id(cur_id)
  );

  always_ff @(posedge clk) begin
    if (rst)         irq_n <= 1'b1;
    else if (ivr_rd) irq_n <= 1'b1;
    else             irq_n <= !qualify;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      if (in_vec)                 bus_rdata <= vec_mem[tbl_idx];
      else if (in_pri)            bus_rdata <= DATA_W'(prio_q[tbl_idx]);
      else if (bus_addr == A_EN)  bus_rdata <= DATA_W'(en_q);
      else if (bus_addr == A_MOD) bus_rdata <= DATA_W'(mode_q);
      else if (bus_addr == A_PND) bus_rdata <= DATA_W'(pend);
      else if (bus_addr == A_SPR) bus_rdata <= spur_q;
      else if (ivr_rd)            bus_rdata <= qualify ? vec_mem[win_id] : spur_q;
      else                        bus_rdata <= '0;
    end
  end

  // R3: the request line is released right after a vector read
  a_r3_read_releases: assert property (@(posedge clk) disable iff (rst)
    ivr_rd |=> irq_n);
  // R5: after a qualifying read the winner is the interrupt in service
  a_r5_winner_current: assert property (@(posedge clk) disable iff (rst)
    push |=> (cur_valid && cur_id == $past(win_id) && cur_lvl == $past(win_prio)));
endmodule

// File: tb/nest_irq_ctrl_tb_top.sv
module nest_irq_ctrl_tb_top;
  localparam int N = 32;
  localparam logic [7:0] A_PRI = 8'd32, A_EN = 8'd64, A_MOD = 8'd65,
                         A_PND = 8'd66, A_VRD = 8'd67, A_EOI = 8'd68, A_SPR = 8'd69;
  localparam logic [31:0] SPUR = 32'h5A5A_0000;
  localparam int ROWS = 8;
  // {pending, enable}
  localparam logic [63:0] TBL [ROWS] = '{
    {32'h0000_0000, 32'hFFFF_FFFF},
    {32'h0000_0001, 32'hFFFF_FFFF},
    {32'h0000_0021, 32'hFFFF_FFFF},
    {32'h0000_0020, 32'h0000_0000},
    {32'h2020_0000, 32'hFFFF_FFFF},
    {32'hFFFF_FFFF, 32'hFFFF_FFDF},
    {32'h0000_0044, 32'hFFFF_FFFF},
    {32'h8000_0100, 32'hFFFF_FFFF}
  };

  logic clk = 1'b0, rst = 1'b1;
  logic [N-1:0] src_in = '0;
  logic bus_sel = 1'b0, bus_wr = 1'b0;
  logic [7:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata, rdv;
  logic irq_n;
  int n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;

  nest_irq_ctrl dut_i (
    .clk(clk), .rst(rst), .src_in(src_in), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_n(irq_n)
  );

  function automatic int prio_of(int i);
    return (i * 3) % 8;
  endfunction
  function automatic logic [31:0] vec_of(int i);
    return 32'hA500_0000 | 32'(i);
  endfunction
  function automatic int ref_win(logic [31:0] p, logic [31:0] e);
    int best = -1;
    for (int i = 0; i < N; i++)
      if (p[i] && e[i] && (best < 0 || prio_of(i) > prio_of(best))) best = i;
    return best;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask
  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask
  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_sel = 1'b0;
    d = bus_rdata;
  endtask
  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    idle(1);
    // R11 reset state
    chk("R11 irq_n after reset", 32'(irq_n), 32'd1);
    rd(A_PND, rdv); chk("R11 pending after reset", rdv, 32'd0);
    rd(A_EN, rdv);  chk("R11 enable after reset", rdv, 32'd0);

    for (int i = 0; i < N; i++) begin
      wr(8'(i), vec_of(i));
      wr(A_PRI + 8'(i), 32'(prio_of(i)));
    end
    wr(A_SPR, SPUR);
    wr(A_MOD, 32'hFFFF_FFFF);
    rd(8'd5, rdv); chk("R11 vector word readback", rdv, vec_of(5));

    // table walk: R1, R2, R3, R4, R6
    for (int r = 0; r < ROWS; r++) begin
      logic [31:0] p, e, expv, expp;
      int w;
      p = TBL[r][63:32]; e = TBL[r][31:0];
      w = ref_win(p, e);
      wr(A_PND, p);
      wr(A_EN, e);
      idle(2);
      chk("R6 request level", 32'(irq_n), (w >= 0) ? 32'd0 : 32'd1);
      rd(A_VRD, rdv);
      expv = (w >= 0) ? vec_of(w) : SPUR;
      chk("R1 R2 vector of winner", rdv, expv);
      chk("R3 released after read", 32'(irq_n), 32'd1);
      expp = (w >= 0) ? (p & ~(32'd1 << w)) : p;
      rd(A_PND, rdv); chk("R4 edge flag cleared by read", rdv, expp);
      if (w >= 0) wr(A_EOI, 32'd0);
      wr(A_PND, 32'd0);
    end

    // nesting: R5 R6 R7 R8 R9
    wr(A_EN, 32'hFFFF_FFFF);
    wr(A_PND, 32'h40); idle(2);                 // src6 prio2
    rd(A_VRD, rdv); chk("R5 first level", rdv, vec_of(6));
    wr(A_PND, 32'h4000); idle(2);               // src14 prio2, equal
    chk("R6 equal level does not preempt", 32'(irq_n), 32'd1);
    wr(A_PND, 32'h80); idle(2);                 // src7 prio5
    chk("R6 higher level preempts", 32'(irq_n), 32'd0);
    rd(A_VRD, rdv); chk("R5 nested level", rdv, vec_of(7));
    wr(A_PND, 32'h02); idle(2);                 // src1 prio3
    chk("R6 lower level waits", 32'(irq_n), 32'd1);
    wr(A_EOI, 32'd0); idle(2);
    chk("R8 reassert after pop", 32'(irq_n), 32'd0);
    rd(A_VRD, rdv); chk("R7 restored level admits prio3", rdv, vec_of(1));
    wr(A_EOI, 32'd0);
    wr(A_EOI, 32'd0);
    wr(A_EOI, 32'd0);                           // empty: ignored
    wr(A_PND, 32'h01); idle(2);                 // src0 prio0
    chk("R9 idle after extra eoi", 32'(irq_n), 32'd0);
    rd(A_VRD, rdv); chk("R9 prio0 taken", rdv, vec_of(0));
    wr(A_PND, 32'h40); idle(2);
    rd(A_VRD, rdv); chk("R5 nest over prio0", rdv, vec_of(6));
    wr(A_EOI, 32'd0);
    wr(A_PND, 32'h08); idle(2);                 // src3 prio1
    chk("R7 restored level 0 after pop", 32'(irq_n), 32'd0);
    rd(A_VRD, rdv); chk("R7 prio1 over restored 0", rdv, vec_of(3));
    wr(A_EOI, 32'd0); wr(A_EOI, 32'd0);

    // spurious read with a higher level in service: R2
    wr(A_PND, 32'h80); idle(2);
    rd(A_VRD, rdv); chk("R5 take prio5", rdv, vec_of(7));
    wr(A_PND, 32'h02); idle(2);
    rd(A_VRD, rdv); chk("R2 spurious under prio5", rdv, SPUR);
    wr(A_EOI, 32'd0); idle(2);
    chk("R2 spurious pushed nothing", 32'(irq_n), 32'd0);
    rd(A_VRD, rdv); chk("R2 prio3 after idle", rdv, vec_of(1));
    wr(A_EOI, 32'd0);
    wr(A_PND, 32'd0);

    // full depth: R8
    begin
      int ids [8] = '{0, 3, 6, 1, 4, 7, 2, 5};
      for (int k = 0; k < 8; k++) begin
        wr(A_PND, 32'd1 << ids[k]); idle(1);
        rd(A_VRD, rdv); chk("R8 deep nesting", rdv, vec_of(ids[k]));
      end
      wr(A_PND, 32'd0);
      repeat (4) wr(A_EOI, 32'd0);
      wr(A_PND, 32'h10); idle(2);               // src4 prio4 above level 3
      chk("R8 level 3 after four pops", 32'(irq_n), 32'd0);
      wr(A_PND, 32'h02); idle(2);               // src1 prio3 equal
      chk("R8 level 3 blocks equal", 32'(irq_n), 32'd1);
      wr(A_PND, 32'd0);
      repeat (4) wr(A_EOI, 32'd0);
      wr(A_PND, 32'h01); idle(2);
      chk("R8 idle after full unwind", 32'(irq_n), 32'd0);
      wr(A_PND, 32'd0);
    end

    // same-cycle edge capture and read clear: R4
    wr(A_PND, 32'h10); idle(1);
    src_in[4] = 1'b1;
    @(negedge clk); @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = A_VRD;
    @(negedge clk);
    bus_sel = 1'b0; rdv = bus_rdata;
    chk("R4 collision read vector", rdv, vec_of(4));
    rd(A_PND, rdv); chk("R4 new edge beats clear", rdv, 32'h10);
    src_in[4] = 1'b0;
    wr(A_EOI, 32'd0);
    rd(A_VRD, rdv); chk("R4 edge still served", rdv, vec_of(4));
    rd(A_PND, rdv); chk("R4 cleared afterwards", rdv, 32'd0);
    wr(A_EOI, 32'd0);

    // level source: R10
    wr(A_MOD, ~32'h80);
    src_in[7] = 1'b1; idle(4);
    chk("R10 level asserts request", 32'(irq_n), 32'd0);
    wr(A_PND, 32'd0);
    rd(A_PND, rdv); chk("R10 write ignored", rdv & 32'h80, 32'h80);
    rd(A_VRD, rdv); chk("R10 level vector", rdv, vec_of(7));
    rd(A_PND, rdv); chk("R10 read does not clear", rdv & 32'h80, 32'h80);
    wr(A_EOI, 32'd0); idle(2);
    chk("R10 reasserts after pop", 32'(irq_n), 32'd0);
    src_in[7] = 1'b0; idle(4);
    rd(A_PND, rdv); chk("R10 follows input low", rdv & 32'h80, 32'd0);
    chk("R10 request released", 32'(irq_n), 32'd1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule